// File: doc/BRIEF.md
# Sequential RC Servo Pulse Generator

This block drives a bank of hobby servo lines from a single shared pulse timer. The channels are served strictly one at a time. A one-hot channel pointer selects the active line. When a pulse starts, that channel's 8-bit position value is captured and the timer is loaded with a fixed base interval plus that value. The selected line is then held high until the timer runs out. At expiry every line is forced low, the timer stops and the pointer moves on to the next channel.

The timer only counts on cycles where the `step_tick` clock enable is asserted. One tick is one resolution step, typically a 4 µs step derived from a divided clock. With the default base of 250 ticks, pulses run from about 1 ms to about 2 ms. Once the last channel has been served, the pointer wraps back to the first channel. The block can also wait for a programmable number of milliseconds before the next sweep starts. During that wait the timer is idle and every line stays low. Position values and the gap length come in as plain register inputs.

Top module: `servo_sweep`

## Requirements
- R1: After reset, all servo lines and `busy_o` are low, the pointer is on channel 0 and the sweep gap counter is zero. The first clock edge after reset is released therefore raises `servo_o[0]`.
- R2: Each pulse keeps its line high for exactly `BASE_TICKS + p` asserted `step_tick` cycles. Here `p` is the channel's position value, taken from `pos_i[i*POS_W +: POS_W]` for channel i.
- R3: While a pulse is running, only the line of the selected channel is high. No more than one line is ever high at once.
- R4: In the cycle after the expiring tick, every line is low and `busy_o` is low. Within a sweep, consecutive pulses are separated by exactly one cycle in which all lines are low.
- R5: Channels are served in ascending order, with channel i driving `servo_o[i]`. After channel `NUM_CH-1`, the next pulse goes to channel 0.
- R6: The position value is captured in the cycle a pulse starts. A change to `pos_i` during a pulse only affects that channel's next pulse.
- R7: `gap_ms_i` is sampled when the last channel's pulse ends. All lines and `busy_o` then stay low for `gap_ms_i * MS_TICKS` ticks, and one cycle later channel 0 starts. A gap of zero gives exactly one idle cycle.
- R8: `busy_o` is high exactly when some servo line is high.
- R9: While a pulse is running and `step_tick` is low, the outputs hold their values. A stalled tick therefore stretches the pulse in cycles but not in ticks.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| step_tick | input | 1 | Clock enable, one assertion per resolution step |
| pos_i | input | NUM_CH*POS_W | Position values; channel i uses bits [i*POS_W +: POS_W] |
| gap_ms_i | input | GAP_W | Pause between sweeps, in milliseconds |
| servo_o | output | NUM_CH | Servo lines, at most one high |
| busy_o | output | 1 | High while a pulse is running |

## Verification
The first sweep uses position values that include 0, 1, 128 and 255. This separates a correct base-plus-value length from an off-by-one error, and from a timer that truncates the top bit of the sum. One sweep changes a position value in the middle of a pulse and stalls the tick for thirty cycles in another pulse. This tells capture-at-start apart from live reading, and tick gating apart from free-running counting. Sweep gaps of zero and three milliseconds are measured in ticks, which exposes prescaler and gap-load errors. A reset in the middle of a pulse shows that the pointer returns to channel 0.

// File: rtl/servo_sweep_pkg.sv
package servo_sweep_pkg;

    // Phase of the shared pulse timer
    typedef enum logic {
        PH_ARM   = 1'b0,   // waiting for the sweep gap to clear, then loads
        PH_PULSE = 1'b1    // one line high, timer counting down on ticks
    } sweep_phase_e;

endpackage

// File: rtl/sweep_pos_sel.sv
// Picks the position value of the channel flagged in a one-hot pointer.
module sweep_pos_sel #(
    parameter int NUM_CH = 8,
    parameter int POS_W  = 8
) (
    input  logic [NUM_CH-1:0]       ptr_i,
    input  logic [NUM_CH*POS_W-1:0] pos_i,
    output logic [POS_W-1:0]        pos_o
);

    logic [POS_W-1:0] masked [NUM_CH];

    for (genvar i = 0; i < NUM_CH; i++) begin : g_mask
        assign masked[i] = ptr_i[i] ? pos_i[i*POS_W +: POS_W] : '0;
    end

    always_comb begin
        pos_o = '0;
        for (int i = 0; i < NUM_CH; i++) begin
            pos_o = pos_o | masked[i];
        end
    end

endmodule

// File: rtl/sweep_pointer.sv
// One-hot channel pointer: steps toward the MSB, wraps to bit 0.
module sweep_pointer #(
    parameter int NUM_CH = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              advance_i,
    output logic [NUM_CH-1:0] ptr_o,
    output logic              last_o
);

    logic [NUM_CH-1:0] ptr_d, ptr_q, stepped;

    // Carry out of the top bit re-enters at bit 0
    for (genvar i = 0; i < NUM_CH; i++) begin : g_step
        if (i == 0) begin : g_low
            assign stepped[i] = ptr_q[NUM_CH-1];
        end else begin : g_up
            assign stepped[i] = ptr_q[i-1];
        end
    end

    always_comb begin
        ptr_d = ptr_q;
        if (advance_i) begin
            ptr_d = stepped;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ptr_q <= NUM_CH'(1);
        end else begin
            ptr_q <= ptr_d;
        end
    end

    assign ptr_o  = ptr_q;
    assign last_o = ptr_q[NUM_CH-1];

endmodule

// File: rtl/sweep_gap_timer.sv
// Millisecond down-counter spacing successive sweeps.
module sweep_gap_timer #(
    parameter int MS_TICKS = 250,
    parameter int GAP_W    = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             step_tick_i,
    input  logic             load_i,
    input  logic [GAP_W-1:0] load_val_i,
    output logic             gap_active_o
);

    localparam int PRE_W = (MS_TICKS > 1) ? $clog2(MS_TICKS) : 1;

    typedef struct packed {
        logic [GAP_W-1:0] frame;
        logic [PRE_W-1:0] pre;
    } gap_t;

    gap_t gap_d, gap_q;

    always_comb begin
        gap_d = gap_q;
        if (load_i) begin
            gap_d.frame = load_val_i;
            gap_d.pre   = '0;
        end else if (gap_q.frame != '0 && step_tick_i) begin
            if (gap_q.pre == PRE_W'(MS_TICKS - 1)) begin
                gap_d.pre   = '0;
                gap_d.frame = gap_q.frame - GAP_W'(1);
            end else begin
                gap_d.pre = gap_q.pre + PRE_W'(1);
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            gap_q <= '0;
        end else begin
            gap_q <= gap_d;
        end
    end

    assign gap_active_o = (gap_q.frame != '0);

endmodule

// File: rtl/servo_sweep.sv
// Shared-timer servo sweeper. BASE_TICKS must be at least 1.
module servo_sweep
    import servo_sweep_pkg::*;
#(
    parameter int NUM_CH     = 8,
    parameter int POS_W      = 8,
    parameter int BASE_TICKS = 250,
    parameter int MS_TICKS   = 250,
    parameter int GAP_W      = 8
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    step_tick,
    input  logic [NUM_CH*POS_W-1:0] pos_i,
    input  logic [GAP_W-1:0]        gap_ms_i,
    output logic [NUM_CH-1:0]       servo_o,
    output logic                    busy_o
);

    localparam int TMR_W = $clog2(BASE_TICKS + (1 << POS_W));

    typedef struct packed {
        sweep_phase_e      phase;
        logic [TMR_W-1:0]  tmr;
        logic [NUM_CH-1:0] servo;
    } core_t;

    core_t core_d, core_q;

    logic [NUM_CH-1:0] ptr;
    logic              ptr_last;
    logic [POS_W-1:0]  cur_pos;
    logic              pulse_done;
    logic              gap_active;
    logic              gap_load;

    sweep_pos_sel #(
        .NUM_CH (NUM_CH),
        .POS_W  (POS_W)
    ) u_sel (
        .ptr_i (ptr),
        .pos_i (pos_i),
        .pos_o (cur_pos)
    );

    sweep_pointer #(
        .NUM_CH (NUM_CH)
    ) u_ptr (
        .clk       (clk),
        .rst_n     (rst_n),
        .advance_i (pulse_done),
        .ptr_o     (ptr),
        .last_o    (ptr_last)
    );

    assign gap_load = pulse_done && ptr_last;

    sweep_gap_timer #(
        .MS_TICKS (MS_TICKS),
        .GAP_W    (GAP_W)
    ) u_gap (
        .clk          (clk),
        .rst_n        (rst_n),
        .step_tick_i  (step_tick),
        .load_i       (gap_load),
        .load_val_i   (gap_ms_i),
        .gap_active_o (gap_active)
    );

    always_comb begin
        core_d     = core_q;
        pulse_done = 1'b0;
        unique case (core_q.phase)
            PH_ARM: begin
                if (!gap_active) begin
                    core_d.phase = PH_PULSE;
                    core_d.tmr   = TMR_W'(BASE_TICKS) + TMR_W'(cur_pos);
                    core_d.servo = ptr;
                end
            end
            PH_PULSE: begin
                if (step_tick) begin
                    if (core_q.tmr == TMR_W'(1)) begin
                        pulse_done   = 1'b1;
                        core_d.phase = PH_ARM;
                        core_d.tmr   = '0;
                        core_d.servo = '0;
                    end else begin
                        core_d.tmr = core_q.tmr - TMR_W'(1);
                    end
                end
            end
            default: core_d = core_q;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            core_q <= '{phase: PH_ARM, tmr: '0, servo: '0};
        end else begin
            core_q <= core_d;
        end
    end

    assign servo_o = core_q.servo;
    assign busy_o  = (core_q.phase == PH_PULSE);

endmodule

// File: rtl/servo_sweep_chk.sv
module servo_sweep_chk #(
    parameter int NUM_CH     = 8,
    parameter int POS_W      = 8,
    parameter int BASE_TICKS = 250
) (
    input logic              clk,
    input logic              rst_n,
    input logic              step_tick,
    input logic [NUM_CH-1:0] servo_o,
    input logic              busy_o
);

    logic [31:0]       len_q;
    logic [NUM_CH-1:0] last_q;
    logic              seen_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            len_q  <= '0;
            last_q <= '0;
            seen_q <= 1'b0;
        end else begin
            if (!busy_o) begin
                len_q <= '0;
            end else if (step_tick) begin
                len_q <= len_q + 32'd1;
            end
            if (busy_o) begin
                last_q <= servo_o;
                seen_q <= 1'b1;
            end
        end
    end

    // R3
    one_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(servo_o));

    // R8
    busy_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        busy_o == (servo_o != '0));

    // R9
    tick_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !step_tick) |=> ($stable(servo_o) && busy_o));

    // R2
    pulse_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(busy_o) |-> (len_q >= 32'(BASE_TICKS)
                           && len_q <= 32'(BASE_TICKS + (1 << POS_W) - 1)));

    // R5
    rotate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(busy_o) && seen_q)
            |-> servo_o == {last_q[NUM_CH-2:0], last_q[NUM_CH-1]});

endmodule

bind servo_sweep servo_sweep_chk #(
    .NUM_CH     (NUM_CH),
    .POS_W      (POS_W),
    .BASE_TICKS (BASE_TICKS)
) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .step_tick (step_tick),
    .servo_o   (servo_o),
    .busy_o    (busy_o)
);

// File: tb/sim_servo_sweep.sv
`timescale 1ns/1ps
module sim_servo_sweep;

    localparam int N    = 8;
    localparam int W    = 8;
    localparam int BASE = 10;
    localparam int MS   = 4;
    localparam int GW   = 4;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           tick = 1'b0;
    logic           stall = 1'b0;
    logic [N*W-1:0] pos = '0;
    logic [GW-1:0]  gap_ms = '0;
    logic [N-1:0]   servo_o;
    logic           busy_o;

    int n_cmp = 0;
    int n_bad = 0;
    int wd = 0;
    int tphase = 0;
    int wv [N] = '{0, 255, 17, 90, 3, 128, 200, 1};

    // behavioural reference state
    bit m_pulse = 1'b0;
    int m_left = 0;
    int m_ch = 0;
    int m_gap = 0;
    int m_pre = 0;

    servo_sweep #(
        .NUM_CH (N), .POS_W (W), .BASE_TICKS (BASE),
        .MS_TICKS (MS), .GAP_W (GW)
    ) u0 (
        .clk (clk), .rst_n (rst_n), .step_tick (tick), .pos_i (pos),
        .gap_ms_i (gap_ms), .servo_o (servo_o), .busy_o (busy_o)
    );

    initial forever #4 clk = ~clk;   // 125 MHz

    // tick every third cycle, changed away from the edge
    initial forever begin
        @(posedge clk);
        #2;
        tphase = (tphase + 1) % 3;
        tick = !stall && rst_n && (tphase == 0);
    end

    task automatic chk(input bit ok, input string req,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) begin
            m_pulse = 1'b0; m_ch = 0; m_gap = 0; m_pre = 0; m_left = 0;
        end else if (m_pulse) begin
            if (tick) begin
                m_left--;
                if (m_left == 0) begin
                    m_pulse = 1'b0;
                    if (m_ch == N - 1) begin
                        m_ch = 0; m_gap = int'(gap_ms); m_pre = 0;
                    end else begin
                        m_ch++;
                    end
                end
            end
        end else if (m_gap != 0) begin
            if (tick) begin
                m_pre++;
                if (m_pre == MS) begin
                    m_pre = 0; m_gap--;
                end
            end
        end else begin
            m_pulse = 1'b1;
            m_left = BASE + int'(pos[m_ch*W +: W]);
        end
    end

    // per-cycle comparison against the reference
    always @(negedge clk) begin
        logic [N-1:0] exp_s;
        string lbl;
        exp_s = m_pulse ? N'(1) << m_ch : '0;
        if (!rst_n) lbl = "R1";
        else if (stall) lbl = "R9";
        else if (m_gap != 0) lbl = "R7";
        else if (m_pulse) lbl = "R2 R3 R5 R6";
        else lbl = "R4";
        chk(servo_o == exp_s, lbl, 32'(servo_o), 32'(exp_s));
        chk(busy_o == m_pulse, "R8", 32'(busy_o), 32'(m_pulse));
    end

    always @(posedge clk) begin
        wd++;
        if (wd > 100000) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=<100000", wd);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    task automatic run_pulse(input int ch, input int exp_len, input bit chg,
                             input int new_w, input bit do_stall);
        int cnt = 0;
        int it = 0;
        logic [N-1:0] snap = '0;
        while (!busy_o) @(negedge clk);
        chk(servo_o == N'(1) << ch, "R5 R3", 32'(servo_o), 32'(N'(1) << ch));
        if (chg) pos[ch*W +: W] = W'(new_w);
        while (busy_o) begin
            if (tick) cnt++;
            if (do_stall && it == 2) begin
                stall = 1'b1;
                snap = servo_o;
            end
            if (do_stall && it == 32) begin
                chk(servo_o == snap && busy_o, "R9", 32'(servo_o), 32'(snap));
                stall = 1'b0;
            end
            it++;
            @(negedge clk);
        end
        chk(cnt == exp_len, chg ? "R6" : "R2", 32'(cnt), 32'(exp_len));
        chk(servo_o == '0, "R4", 32'(servo_o), 32'd0);
    endtask

    task automatic run_gap(input int exp_ticks, input int exp_cyc);
        int cnt = 0;
        int cyc = 0;
        while (!busy_o) begin
            if (tick) cnt++;
            cyc++;
            @(negedge clk);
        end
        chk(cnt == exp_ticks, "R7", 32'(cnt), 32'(exp_ticks));
        if (exp_cyc >= 0) chk(cyc == exp_cyc, "R7", 32'(cyc), 32'(exp_cyc));
    endtask

    initial begin
        for (int i = 0; i < N; i++) pos[i*W +: W] = W'(wv[i]);
        repeat (4) @(negedge clk);
        chk(servo_o == '0 && !busy_o, "R1", 32'(servo_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(servo_o == N'(1), "R1", 32'(servo_o), 32'd1);

        // sweep 1: spread of values, no gap
        for (int ch = 0; ch < N; ch++) run_pulse(ch, BASE + wv[ch], 1'b0, 0, 1'b0);
        run_gap(0, 1);

        // sweep 2: mid-pulse value change, tick stall, 3 ms gap
        for (int ch = 0; ch < N; ch++) begin
            if (ch == 6) gap_ms = GW'(3);
            run_pulse(ch, BASE + wv[ch], ch == 3, 40, ch == 5);
        end
        wv[3] = 40;
        run_gap(3 * MS, -1);
        gap_ms = '0;

        // sweep 3: changed value now in effect
        for (int ch = 0; ch < N; ch++) run_pulse(ch, BASE + wv[ch], 1'b0, 0, 1'b0);
        run_gap(0, 1);

        // reset in the middle of a pulse
        run_pulse(0, BASE + wv[0], 1'b0, 0, 1'b0);
        while (!busy_o) @(negedge clk);
        repeat (5) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        chk(servo_o == '0 && !busy_o, "R1", 32'(servo_o), 32'd0);
        rst_n = 1'b1;
        @(negedge clk);
        chk(servo_o == N'(1), "R1", 32'(servo_o), 32'd1);
        repeat (3) @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule